// File: doc/BRIEF.md
# Shift-Coefficient DC Blocking Filter

This block removes the DC component from a stream of signed 24-bit samples arriving on two interleaved channels. Each accepted sample passes through a first-order high-pass recursion whose feedback coefficient is a power of two, 2^-(k+1). The 4-bit global code k selects that coefficient, so the datapath needs only shifters and adders. Every channel keeps its own previous input and its own filter accumulator. A sample on one channel never disturbs the state of the other.

A global code of zero turns filtering off for every channel. A per-channel bypass bit turns it off for one channel only. A channel that is off passes its samples through unchanged and holds its state at zero, so that when it is turned back on it starts from a clean state. Results appear one clock after the input strobe, together with the channel index of the sample.

Top module: `dcb_filter`

## Requirements
- R1: While rst_ni is low, and after it is released with no sample applied, valid_o is 0 and data_o is 0.
- R2: A sample accepted with valid_i high on a rising edge produces valid_o high on the following edge, with ch_o equal to that sample's ch_i. When valid_i is low, valid_o goes low and data_o keeps its previous value.
- R3: When code_i is 0, data_o equals the input sample exactly, on every channel.
- R4: When a channel's bit in ch_bypass_i is 1 (bit c belongs to channel c), that channel's data_o equals its input sample exactly. When the bit is 0, the channel follows code_i.
- R5: For an enabled channel with code k in 1..15, the state Y (the output scaled by 2^8 guard bits) updates as Y' = Y + (x - x_prev)*2^8 - floor(Y / 2^(k+1)), and x_prev becomes x.
- R6: The output is floor((Y' + 2^7) / 2^8), saturated to the range -2^23 .. 2^23-1.
- R7: The state of each channel is independent: interleaving samples of the two channels gives the same per-channel results as running each channel alone.
- R8: While a channel is disabled (by code 0 or by its bypass bit) its Y and x_prev are zero, so the first sample after it is re-enabled yields data_o equal to that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 4 | Global coefficient code; 0 = filtering off, k = coefficient 2^-(k+1) |
| ch_bypass_i | input | 2 | Per-channel bypass, bit c for channel c |
| valid_i | input | 1 | Input sample strobe |
| ch_i | input | 1 | Channel index of the input sample |
| data_i | input | 24 | Signed input sample |
| valid_o | output | 1 | Output sample strobe |
| ch_o | output | 1 | Channel index of the output sample |
| data_o | output | 24 | Signed filtered or passed-through sample |

## Verification
The bench sweeps all sixteen codes against all four bypass combinations. In each combination it sends steps, full-scale alternations, pseudo-random values and ramps, first in channel runs and then interleaved sample by sample. A wrong shift amount shows up as a different decay on steps. Truncating instead of rounding makes the output one LSB off. A missing output clamp makes a full-scale swing wrap to the opposite sign. A shared or crossed state register corrupts the interleaved runs. A channel that keeps its state while disabled returns a transient on its first re-enabled sample instead of the sample itself.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned DCB_NUM_CH  = 2;
  localparam int unsigned DCB_DATA_W  = 24;
  localparam int unsigned DCB_GUARD_W = 8;
  localparam int unsigned DCB_CODE_W  = 4;
endpackage

// File: rtl/dcb_sat.sv
module dcb_sat #(
  parameter int unsigned IN_W  = 34,
  parameter int unsigned OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  d_i,
  output logic signed [OUT_W-1:0] q_o
);
  if (IN_W > OUT_W) begin : g_clip
    logic in_range;
    assign in_range = (&d_i[IN_W-1:OUT_W-1]) | ~(|d_i[IN_W-1:OUT_W-1]);
    assign q_o = in_range ? d_i[OUT_W-1:0]
                          : {d_i[IN_W-1], {(OUT_W-1){~d_i[IN_W-1]}}};
  end else begin : g_ext
    assign q_o = OUT_W'(d_i);
  end
endmodule

// File: rtl/dcb_shift.sv
module dcb_shift #(
  parameter int unsigned ACC_W  = 34,
  parameter int unsigned CODE_W = 4
) (
  input  logic signed [ACC_W-1:0] y_i,
  input  logic [CODE_W-1:0]       code_i,
  output logic signed [ACC_W-1:0] y_o
);
  localparam int unsigned NUM_SEL = 2 ** CODE_W;

  logic signed [ACC_W-1:0] cand [NUM_SEL];

  // code k scales by 2^-(k+1); entry 0 unused by the enabled path
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sh
    assign cand[k] = y_i >>> (k + 1);
  end

  assign y_o = cand[code_i];
endmodule

// File: rtl/dcb_datapath.sv
module dcb_datapath #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned CODE_W  = 4,
  localparam int unsigned ACC_W  = DATA_W + GUARD_W + 2
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] xp_i,
  input  logic signed [ACC_W-1:0]  y_i,
  input  logic [CODE_W-1:0]        code_i,
  output logic signed [ACC_W-1:0]  y_o,
  output logic signed [DATA_W-1:0] d_o
);
  localparam int unsigned SUM_W = ACC_W + 2;
  localparam int unsigned Q_W   = ACC_W + 1 - GUARD_W;
  localparam logic signed [ACC_W:0] RND_HALF =
    {{(ACC_W+1-GUARD_W){1'b0}}, 1'b1, {(GUARD_W-1){1'b0}}};

  logic signed [DATA_W:0]  x_ext, xp_ext, diff;
  logic signed [SUM_W-1:0] diff_w, diff_sh, y_w, shr_w, sum_w;
  logic signed [ACC_W-1:0] y_shr;
  logic signed [ACC_W:0]   y_n_w, rnd_w;
  logic signed [Q_W-1:0]   q_full;

  dcb_shift #(.ACC_W(ACC_W), .CODE_W(CODE_W)) i_shift (
    .y_i    (y_i),
    .code_i (code_i),
    .y_o    (y_shr)
  );

  assign x_ext   = x_i;
  assign xp_ext  = xp_i;
  assign diff    = x_ext - xp_ext;
  assign diff_w  = diff;
  assign diff_sh = diff_w <<< GUARD_W;
  assign y_w     = y_i;
  assign shr_w   = y_shr;
  assign sum_w   = y_w + diff_sh - shr_w;

  dcb_sat #(.IN_W(SUM_W), .OUT_W(ACC_W)) i_sat_acc (
    .d_i (sum_w),
    .q_o (y_o)
  );

  assign y_n_w  = y_o;
  assign rnd_w  = y_n_w + RND_HALF;
  assign q_full = rnd_w[ACC_W:GUARD_W];

  dcb_sat #(.IN_W(Q_W), .OUT_W(DATA_W)) i_sat_out (
    .d_i (q_full),
    .q_o (d_o)
  );
endmodule

// File: rtl/dcb_state_bank.sv
module dcb_state_bank #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ACC_W  = 34,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        clr_i,
  input  logic                     wr_en_i,
  input  logic [CH_W-1:0]          ch_i,
  input  logic signed [DATA_W-1:0] xp_wr_i,
  input  logic signed [ACC_W-1:0]  y_wr_i,
  output logic signed [DATA_W-1:0] xp_rd_o,
  output logic signed [ACC_W-1:0]  y_rd_o
);
  logic signed [DATA_W-1:0] xp_q [NUM_CH];
  logic signed [ACC_W-1:0]  y_q  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        xp_q[c] <= '0;
        y_q[c]  <= '0;
      end else if (clr_i[c]) begin
        xp_q[c] <= '0;
        y_q[c]  <= '0;
      end else if (wr_en_i && (ch_i == CH_W'(c))) begin
        xp_q[c] <= xp_wr_i;
        y_q[c]  <= y_wr_i;
      end
    end
  end

  assign xp_rd_o = xp_q[ch_i];
  assign y_rd_o  = y_q[ch_i];
endmodule

// File: rtl/dcb_filter.sv
module dcb_filter
  import dcb_pkg::*;
#(
  parameter int unsigned NUM_CH  = DCB_NUM_CH,
  parameter int unsigned DATA_W  = DCB_DATA_W,
  parameter int unsigned GUARD_W = DCB_GUARD_W,
  parameter int unsigned CODE_W  = DCB_CODE_W,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ACC_W  = DATA_W + GUARD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [NUM_CH-1:0] ch_bypass_i,
  input  logic              valid_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DATA_W-1:0] data_o
);
  logic [NUM_CH-1:0]        ch_on;
  logic                     sel_on;
  logic signed [DATA_W-1:0] x_s, xp_rd, filt_d;
  logic signed [ACC_W-1:0]  y_rd, y_nxt;

  assign ch_on  = (code_i != '0) ? ~ch_bypass_i : '0;
  assign sel_on = ch_on[ch_i];
  assign x_s    = data_i;

  dcb_state_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ACC_W(ACC_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~ch_on),
    .wr_en_i (valid_i & sel_on),
    .ch_i    (ch_i),
    .xp_wr_i (x_s),
    .y_wr_i  (y_nxt),
    .xp_rd_o (xp_rd),
    .y_rd_o  (y_rd)
  );

  dcb_datapath #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .CODE_W(CODE_W)) i_dp (
    .x_i    (x_s),
    .xp_i   (xp_rd),
    .y_i    (y_rd),
    .code_i (code_i),
    .y_o    (y_nxt),
    .d_o    (filt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ch_o   <= ch_i;
        data_o <= sel_on ? filt_d : data_i;
      end
    end
  end
endmodule

// File: rtl/dcb_filter_chk.sv
module dcb_filter_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CH_W   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic [NUM_CH-1:0] ch_bypass_i,
  input logic              valid_i,
  input logic [CH_W-1:0]   ch_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_o,
  input logic [CH_W-1:0]   ch_o,
  input logic [DATA_W-1:0] data_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!valid_o && data_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  a_r2_channel_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ch_o == $past(ch_i));
  a_r3_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && code_i == '0) |=> data_o == $past(data_i));
  a_r4_chan_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ch_bypass_i[ch_i]) |=> data_o == $past(data_i));
endmodule

bind dcb_filter dcb_filter_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .CODE_W (CODE_W),
  .CH_W   (CH_W)
) i_dcb_filter_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .code_i      (code_i),
  .ch_bypass_i (ch_bypass_i),
  .valid_i     (valid_i),
  .ch_i        (ch_i),
  .data_i      (data_i),
  .valid_o     (valid_o),
  .ch_o        (ch_o),
  .data_o      (data_o)
);

// File: tb/test_dcb_filter.sv
module test_dcb_filter;
  localparam int G = 8;
  localparam int DW = 24;
  localparam time CLK_P = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  code_i = '0;
  logic [1:0]  ch_bypass_i = '0;
  logic        valid_i = 1'b0;
  logic        ch_i = 1'b0;
  logic [23:0] data_i = '0;
  logic        valid_o;
  logic        ch_o;
  logic [23:0] data_o;

  int vectors = 0;
  int fails = 0;
  longint ys [2];
  longint xp [2];
  bit fresh [2];
  int last_ch = 0;
  int cur_code = 0;
  logic [1:0] cur_byp = '0;
  logic [31:0] lfsr = 32'h1badcafe;

  always #(CLK_P/2) clk_i = ~clk_i;

  dcb_filter i_dcb_filter (
    .clk_i, .rst_ni, .code_i, .ch_bypass_i, .valid_i, .ch_i, .data_i,
    .valid_o, .ch_o, .data_o
  );

  function automatic longint sat(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic apply_cfg(int code, logic [1:0] byp);
    @(negedge clk_i);
    valid_i = 1'b0;
    code_i = code[3:0];
    ch_bypass_i = byp;
    cur_code = code;
    cur_byp = byp;
    for (int c = 0; c < 2; c++) begin
      if (code == 0 || byp[c]) begin
        ys[c] = 0; xp[c] = 0; fresh[c] = 1'b1;
      end
    end
    @(posedge clk_i);
  endtask

  task automatic send(int ch, longint x);
    longint expv, yn, r;
    string tag;
    @(negedge clk_i);
    valid_i = 1'b1;
    ch_i = ch[0];
    data_i = x[23:0];
    if (cur_code == 0 || cur_byp[ch]) begin
      expv = x;
      tag = (cur_code == 0) ? "R3" : "R4";
      ys[ch] = 0; xp[ch] = 0; fresh[ch] = 1'b1;
    end else begin
      yn = ys[ch] + ((x - xp[ch]) <<< G) - (ys[ch] >>> (cur_code + 1));
      ys[ch] = yn;
      xp[ch] = x;
      r = (yn + (longint'(1) <<< (G - 1))) >>> G;
      expv = sat(r, DW);
      if (fresh[ch]) tag = "R8";
      else if (r != expv) tag = "R6";
      else if (last_ch != ch) tag = "R7";
      else tag = "R5";
      fresh[ch] = 1'b0;
    end
    last_ch = ch;
    @(posedge clk_i);
    #1;
    chk(valid_o === 1'b1 && ch_o === ch[0], "R2", {valid_o, ch_o}, {1'b1, ch[0]});
    chk(longint'($signed(data_o)) == expv, tag, longint'($signed(data_o)), expv);
  endtask

  task automatic idle_check(int n);
    logic [23:0] held;
    @(negedge clk_i);
    valid_i = 1'b0;
    held = data_o;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
      chk(valid_o === 1'b0 && data_o === held, "R2", data_o, held);
    end
  endtask

  function automatic longint stim(int i);
    longint v;
    case (i / 8)
      0: v = longint'(1) <<< 22;
      1: v = (i % 2) ? (longint'(1) <<< 23) - 1 : -(longint'(1) <<< 23);
      2: begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        v = longint'($signed(lfsr[23:0]));
      end
      default: v = -(longint'(1) <<< 23) + longint'(i) * 524288;
    endcase
    return v;
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL R2: watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      ys[c] = 0; xp[c] = 0; fresh[c] = 1'b1;
    end
    repeat (3) @(posedge clk_i);
    #1;
    chk(valid_o === 1'b0 && data_o === '0, "R1", data_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    chk(valid_o === 1'b0 && data_o === '0, "R1", data_o, 0);

    // sweep every code against every bypass pattern
    for (int code = 0; code < 16; code++) begin
      for (int b = 0; b < 4; b++) begin
        apply_cfg(code, b[1:0]);
        for (int i = 0; i < 32; i++) begin
          send((i < 16) ? ((i >> 2) & 1) : (i & 1), stim(i));
        end
      end
      idle_check(2);
    end

    // R8: disable one channel mid-stream, re-enable, first sample passes exact
    apply_cfg(3, 2'b00);
    for (int i = 0; i < 6; i++) send(0, 1000 * (i + 1));
    apply_cfg(3, 2'b01);
    send(0, 77);
    apply_cfg(3, 2'b00);
    send(0, 12345);
    send(0, 12345);
    apply_cfg(0, 2'b00);
    apply_cfg(5, 2'b00);
    send(1, -4321);
    idle_check(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule